// File: doc/BRIEF.md
# Fixed Off-Time Peak-Current Chopper

This block drives the four gate enables of one H-bridge so that the coil current follows a peak limit set elsewhere. Each chopping cycle starts by driving the coil in the direction given by the polarity input. For a programmable blanking window after turn-on, the current-limit comparator is ignored, so the switching spike cannot end the on period early. After the window, the first trip report ends the on period. An off period of fixed length follows. The off period uses either slow decay, with both low-side switches on for synchronous rectification, or mixed decay, where a reversed-drive fast phase comes first and slow decay takes the rest.

Each time the gate pattern changes, the block first holds all four gates off for a dead interval of fixed length. A change of polarity drops the current phase and starts a fresh on period in the new direction after one such interval. A low enable or an active fault input turns every gate off in the same cycle and sends the sequencer back to idle. All intervals are parameters counted in clock cycles.

Top module: `pwm_chopper`

## Requirements
- R1: While enable is low, all four gates are off in the same cycle and the sequencer stays idle. The first cycle after enable rises is idle, with gates off. DEAD_CYC cycles with all gates off follow, and only then does drive begin. Reset gives the same all-off idle state.
- R2: Drive pattern, as {gate_ah, gate_al, gate_bh, gate_bl}: polarity 1 gives 1001 (leg A high, leg B low) and polarity 0 gives 0110 (leg B high, leg A low).
- R3: For the first BLANK_CYC cycles of every on period, trip has no effect and drive is held. After that, drive continues as long as trip stays low.
- R4: A trip sampled high after blanking ends the on period. From the next cycle, all gates are off for DEAD_CYC cycles.
- R5: With decay_mixed low at the trip, the off period is 0101 (both low sides) for OFF_CYC cycles. DEAD_CYC all-off cycles follow, then a new blanked on period.
- R6: With decay_mixed high at the trip, the off period is first the reversed drive pattern for FAST_CYC cycles, then DEAD_CYC all-off cycles, then 0101 for OFF_CYC-FAST_CYC cycles. DEAD_CYC all-off cycles follow, then a new on period.
- R7: If polarity differs from the direction in use during any active phase, the current cycle shows the old pattern. All gates are then off for DEAD_CYC cycles, and a new blanked on period starts in the new direction.
- R8: Fault high turns all gates off in the same cycle and returns the sequencer to idle. After fault clears, restart follows R1.
- R9: The high and low gates of one leg are never on together.
- R10: A gate turns on only in a cycle that follows a cycle with all gates off.
- R11: A high-side gate is on only together with the low-side gate of the other leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low holds idle with gates off |
| polarity | input | 1 | Current direction: 1 = A to B, 0 = B to A |
| trip | input | 1 | Peak-current comparator output, active high |
| decay_mixed | input | 1 | Off-period mode: 0 = slow decay, 1 = mixed decay |
| fault | input | 1 | Protection fault, active high; forces all gates off |
| gate_ah | output | 1 | Leg A high-side gate enable |
| gate_al | output | 1 | Leg A low-side gate enable |
| gate_bh | output | 1 | Leg B high-side gate enable |
| gate_bl | output | 1 | Leg B low-side gate enable |

## Verification
The bench holds trip high through the whole blanking window. A sequencer that does not blank would cut the on period short and show the dead gap too early. Both decay modes are traced cycle by cycle in both directions. A design that left out the fast phase, used the wrong fast direction, or miscounted the slow remainder (OFF_CYC-FAST_CYC) would be off by one pattern or by a few cycles. Polarity is flipped once while drive is on and once during slow decay. A design that switched diagonals directly, without the all-off gap, would break the break-before-make check. Fault and enable drops are checked in the cycle they arrive, so a version that only stops at the next clock edge would show one live cycle.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_BLANK,
    ST_ARMED,
    ST_FAST,
    ST_SLOW
  } chop_state_e;

  typedef struct packed {
    logic ah;
    logic al;
    logic bh;
    logic bl;
  } gate_t;

  localparam gate_t GATES_OFF = '{ah: 1'b0, al: 1'b0, bh: 1'b0, bl: 1'b0};

  // Diagonal drive: pol=1 pushes current from leg A to leg B.
  function automatic gate_t drive_pattern(input logic pol);
    gate_t g;
    g.ah = pol;
    g.bl = pol;
    g.bh = ~pol;
    g.al = ~pol;
    return g;
  endfunction

  // Synchronous slow decay: both low sides conduct.
  function automatic gate_t slow_pattern();
    return '{ah: 1'b0, al: 1'b1, bh: 1'b0, bl: 1'b1};
  endfunction

  // Cycles of slow decay within the off period.
  function automatic int slow_cycles(input int off_cyc, input int fast_cyc,
                                     input logic mixed);
    return mixed ? (off_cyc - fast_cyc) : off_cyc;
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 100,
  parameter int OFF_CYC   = 3000,
  parameter int FAST_CYC  = 1000,
  parameter int DEAD_CYC  = 48,
  parameter int TW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          fault,
  input  logic          polarity,
  input  logic          trip,
  input  logic          decay_mixed,
  input  logic          tmr_done,
  output chop_state_e   state,
  output logic          pol_q,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          halt,
  output logic          pol_change,
  output logic          trip_taken
);
  chop_state_e state_q, state_d, nxt_q, nxt_d;
  logic        mixed_q;

  localparam logic [TW-1:0] DEAD_V  = TW'(DEAD_CYC - 1);
  localparam logic [TW-1:0] BLANK_V = TW'(BLANK_CYC - 1);
  localparam logic [TW-1:0] FAST_V  = TW'(FAST_CYC - 1);
  localparam logic [TW-1:0] SLOWM_V = TW'(slow_cycles(OFF_CYC, FAST_CYC, 1'b1) - 1);
  localparam logic [TW-1:0] SLOWS_V = TW'(slow_cycles(OFF_CYC, FAST_CYC, 1'b0) - 1);

  assign halt       = ~enable | fault;
  assign pol_change = ~halt && (state_q != ST_IDLE) && (polarity != pol_q);
  assign trip_taken = ~halt && ~pol_change && (state_q == ST_ARMED) && trip;

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    tmr_load = 1'b0;
    tmr_val  = DEAD_V;
    if (halt) begin
      state_d = ST_IDLE;
    end else if (pol_change) begin
      state_d  = ST_GAP;
      nxt_d    = ST_BLANK;
      tmr_load = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d  = ST_GAP;
          nxt_d    = ST_BLANK;
          tmr_load = 1'b1;
        end
        ST_GAP: if (tmr_done) begin
          state_d  = nxt_q;
          tmr_load = 1'b1;
          unique case (nxt_q)
            ST_FAST: tmr_val = FAST_V;
            ST_SLOW: tmr_val = mixed_q ? SLOWM_V : SLOWS_V;
            default: tmr_val = BLANK_V;
          endcase
        end
        ST_BLANK: if (tmr_done) state_d = ST_ARMED;
        ST_ARMED: if (trip) begin
          state_d  = ST_GAP;
          nxt_d    = decay_mixed ? ST_FAST : ST_SLOW;
          tmr_load = 1'b1;
        end
        ST_FAST: if (tmr_done) begin
          state_d  = ST_GAP;
          nxt_d    = ST_SLOW;
          tmr_load = 1'b1;
        end
        ST_SLOW: if (tmr_done) begin
          state_d  = ST_GAP;
          nxt_d    = ST_BLANK;
          tmr_load = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_BLANK;
      pol_q   <= 1'b1;
      mixed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      nxt_q   <= nxt_d;
      if (state_q == ST_IDLE || state_d == ST_IDLE || pol_change) pol_q <= polarity;
      if (trip_taken) mixed_q <= decay_mixed;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
  import chop_pkg::*;
(
  input  chop_state_e state,
  input  logic        pol_q,
  input  logic        halt,
  output gate_t       gates
);
  always_comb begin
    unique case (state)
      ST_BLANK, ST_ARMED: gates = drive_pattern(pol_q);
      ST_FAST:            gates = drive_pattern(~pol_q);
      ST_SLOW:            gates = slow_pattern();
      default:            gates = GATES_OFF;
    endcase
    if (halt) gates = GATES_OFF;
  end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 100,
  parameter int OFF_CYC   = 3000,
  parameter int FAST_CYC  = 1000,
  parameter int DEAD_CYC  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic polarity,
  input  logic trip,
  input  logic decay_mixed,
  input  logic fault,
  output logic gate_ah,
  output logic gate_al,
  output logic gate_bh,
  output logic gate_bl
);
  localparam int MAX_A   = (BLANK_CYC > DEAD_CYC) ? BLANK_CYC : DEAD_CYC;
  localparam int MAX_LEN = (OFF_CYC > MAX_A) ? OFF_CYC : MAX_A;
  localparam int TW      = $clog2(MAX_LEN + 1) + 1;

  chop_state_e   state;
  logic          pol_q, tmr_load, tmr_done, halt, pol_change, trip_taken;
  logic [TW-1:0] tmr_val;
  gate_t         gates;

  chop_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  chop_seq #(
    .BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC), .FAST_CYC(FAST_CYC),
    .DEAD_CYC(DEAD_CYC), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
    .polarity(polarity), .trip(trip), .decay_mixed(decay_mixed),
    .tmr_done(tmr_done), .state(state), .pol_q(pol_q),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .halt(halt),
    .pol_change(pol_change), .trip_taken(trip_taken)
  );

  chop_gate_map u_map (
    .state(state), .pol_q(pol_q), .halt(halt), .gates(gates)
  );

  assign gate_ah = gates.ah;
  assign gate_al = gates.al;
  assign gate_bh = gates.bh;
  assign gate_bl = gates.bl;
endmodule

// File: rtl/chop_checker.sv
module chop_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic fault,
  input logic gate_ah,
  input logic gate_al,
  input logic gate_bh,
  input logic gate_bl,
  input logic trip_taken
);
  logic [3:0] g;
  assign g = {gate_ah, gate_al, gate_bh, gate_bl};

  assert_leg_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ah && gate_al) && !(gate_bh && gate_bl));

  assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (g == 4'b0000));

  assert_enable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (g == 4'b0000));

  assert_break_before_make_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((g & ~$past(g)) != 4'b0000) |-> ($past(g) == 4'b0000));

  assert_diagonal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ah |-> gate_bl) and (gate_bh |-> gate_al));

  assert_trip_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_taken |=> (g == 4'b0000));
endmodule

bind pwm_chopper chop_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
  .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl),
  .trip_taken(trip_taken)
);

// File: tb/pwm_chopper_bench.sv
`timescale 1ns/1ps
module pwm_chopper_bench;
  localparam int BLK  = 6;
  localparam int OFF  = 20;
  localparam int FST  = 8;
  localparam int DT   = 3;
  localparam logic [3:0] OFFP = 4'b0000;
  localparam logic [3:0] FWD  = 4'b1001;
  localparam logic [3:0] REV  = 4'b0110;
  localparam logic [3:0] SLW  = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, polarity = 1'b1, trip = 1'b0, decay_mixed = 1'b0, fault = 1'b0;
  logic gate_ah, gate_al, gate_bh, gate_bl;
  int   n_chk = 0, n_fail = 0;
  logic [3:0] prev = 4'b0000;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pwm_chopper #(.BLANK_CYC(BLK), .OFF_CYC(OFF), .FAST_CYC(FST), .DEAD_CYC(DT)) u_pwm_chopper (
    .clk(clk), .rst_n(rst_n), .enable(enable), .polarity(polarity), .trip(trip),
    .decay_mixed(decay_mixed), .fault(fault),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh), .gate_bl(gate_bl)
  );

  // Sample the current cycle 1 ns after the falling edge, then move on one cycle.
  task automatic chk(input logic [3:0] exp, input string req);
    logic [3:0] got;
    #1;
    got = {gate_ah, gate_al, gate_bh, gate_bl};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: gates got %b expected %b at %0t", req, got, exp, $time);
    end
    n_chk++;
    if ((got[3] & got[2]) | (got[1] & got[0]) | (got[3] & ~got[0]) | (got[1] & ~got[2]) |
        (((got & ~prev) != 4'b0000) && (prev != 4'b0000))) begin
      n_fail++;
      $display("FAIL R9 R10 R11: gates got %b after %b, expected safe pattern", got, prev);
    end
    prev = got;
    @(negedge clk);
  endtask

  task automatic run(input logic [3:0] exp, input int n, input string req);
    for (int i = 0; i < n; i++) chk(exp, req);
  endtask

  task automatic t_reset();
    enable = 1'b1;
    @(negedge clk);
    run(OFFP, 3, "R1 reset");
    rst_n = 1'b1;
    enable = 1'b0;
    run(OFFP, 3, "R1 disabled");
  endtask

  task automatic t_start_blank();
    polarity = 1'b1;
    enable = 1'b1;
    chk(OFFP, "R1 idle cycle");
    run(OFFP, DT, "R1 start gap");
    trip = 1'b1;
    run(FWD, BLK, "R3 blanked trip R2");
    trip = 1'b0;
    run(FWD, 4, "R3 armed hold");
  endtask

  task automatic t_slow();
    trip = 1'b1; decay_mixed = 1'b0;
    chk(FWD, "R4 trip cycle");
    trip = 1'b0;
    run(OFFP, DT, "R4 gap");
    run(SLW, OFF, "R5 slow decay");
    run(OFFP, DT, "R5 gap");
    run(FWD, BLK + 2, "R5 new on");
  endtask

  task automatic t_mixed(input logic [3:0] on, input logic [3:0] fast);
    trip = 1'b1; decay_mixed = 1'b1;
    chk(on, "R6 trip cycle");
    trip = 1'b0; decay_mixed = 1'b0;
    run(OFFP, DT, "R6 gap1");
    run(fast, FST, "R6 fast");
    run(OFFP, DT, "R6 gap2");
    run(SLW, OFF - FST, "R6 slow");
    run(OFFP, DT, "R6 gap3");
    run(on, BLK + 1, "R6 new on");
  endtask

  task automatic t_pol_armed();
    polarity = 1'b0;
    chk(FWD, "R7 old pattern");
    run(OFFP, DT, "R7 gap");
    run(REV, BLK + 3, "R7 reverse R2");
  endtask

  task automatic t_pol_in_slow();
    trip = 1'b1;
    chk(REV, "R7 trip");
    trip = 1'b0;
    run(OFFP, DT, "R7 gap");
    run(SLW, 5, "R7 slow");
    polarity = 1'b1;
    chk(SLW, "R7 change cycle");
    run(OFFP, DT, "R7 change gap");
    run(FWD, BLK + 1, "R7 forward");
  endtask

  task automatic t_fault();
    fault = 1'b1;
    run(OFFP, 2, "R8 fault");
    fault = 1'b0;
    chk(OFFP, "R8 idle");
    run(OFFP, DT, "R8 gap");
    run(FWD, BLK + 1, "R8 restart");
  endtask

  task automatic t_enable_drop();
    trip = 1'b1;
    chk(FWD, "R1 trip");
    trip = 1'b0;
    run(OFFP, DT, "R1 gap");
    run(SLW, 4, "R1 slow");
    enable = 1'b0;
    run(OFFP, 3, "R1 enable low");
    enable = 1'b1;
    chk(OFFP, "R1 idle");
    run(OFFP, DT, "R1 gap");
    run(FWD, BLK, "R1 restart");
  endtask

  initial begin
    t_reset();
    t_start_blank();
    t_slow();
    t_mixed(FWD, REV);
    t_pol_armed();
    t_mixed(REV, FWD);
    t_pol_in_slow();
    t_fault();
    t_enable_drop();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule